// File: doc/BRIEF.md
# SRAM Fingerprint Stability and Balance Evaluator

This block scores the quality of an SRAM power-up fingerprint in hardware. A run opens with a single-cycle start pulse. The readout that follows is stored as the reference signature. After it, the block takes a programmed number of further noisy readouts of the same array. For each cell it keeps a counter of how often the cell disagreed with the reference. A cell whose count ends above a programmable flip limit is marked unstable.

When the last noisy readout has been taken in, a shared sequential divider works out two figures. The first is the share of unstable cells as a percentage. The second is the balance of the reference signature: its percentage of ones and that value's distance from the ideal 50 %. Both figures are fixed point with 8 fractional bits, so 100 % reads as 25600. Readouts arrive one word per cycle over a valid/ready stream. The block also keeps running maxima across runs, for example one run per temperature corner, so that the worst corner can be read out.

Top module: `puf_quality_eval`

## Requirements
- R1: After reset every result output is zero, `res_done` is low and `in_ready` is low.
- R2: One cycle after a start pulse, `in_ready` goes high. The next ceil(CELLS/WORD_W) accepted words form the reference signature. Bit b of word k belongs to cell k*WORD_W+b.
- R3: A cell's flip count is the number of noisy readouts in which its bit differs from the reference. The cell is unstable when that count is greater than the flip limit latched at start. `res_unrel_cnt` is the number of unstable cells.
- R4: With a flip limit of 0, a single disagreement makes a cell unstable. With a flip limit at or above the readout count, no cell is unstable.
- R5: `res_unrel_pct` equals floor(res_unrel_cnt*25600/CELLS).
- R6: `res_hw` is the number of ones among the CELLS reference bits. Padding bits above cell CELLS-1 in the last word have no effect on any result.
- R7: `res_uni_dev` equals |floor(res_hw*25600/CELLS) - 12800|.
- R8: At each completion, `res_max_unrel_pct` and `res_max_uni_dev` become the larger of their old value and the new result. A start with `in_sweep_new` high clears both maxima to zero.
- R9: `res_done` is a one-cycle pulse at which all results are valid. After it, `in_ready` is low until the next start. A readout count of 0 completes after the reference with zero unstable cells.
- R10: A start pulse during a run abandons that run. Nothing from the abandoned run reaches the results or the maxima.
- R11: The readout count is latched at start and clamped to MAX_NOISY. The run then completes after exactly that many noisy readouts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_start | input | 1 | Start pulse; begins a run with the reference readout |
| in_sweep_new | input | 1 | Sampled with start; clears the cross-run maxima |
| cfg_noisy_runs | input | CFG_W | Number of noisy readouts, latched at start |
| cfg_flip_limit | input | CFG_W | Flip limit, latched at start |
| in_valid | input | 1 | Readout word valid |
| in_word | input | WORD_W | Readout word |
| in_ready | output | 1 | Block accepts a readout word |
| res_done | output | 1 | One-cycle completion pulse |
| res_unrel_cnt | output | CELL_W | Number of unstable cells |
| res_unrel_pct | output | PCT_W | Unstable-cell percentage, 8 fractional bits |
| res_hw | output | CELL_W | Ones in the reference signature |
| res_uni_dev | output | PCT_W | Distance of the ones percentage from 50 %, 8 fractional bits |
| res_max_unrel_pct | output | PCT_W | Largest unstable percentage since the sweep was cleared |
| res_max_uni_dev | output | PCT_W | Largest balance deviation since the sweep was cleared |

## Verification
The hardest state to reach is an abandoned run. The reference store and part of the counter array already hold data from one signature when a second start arrives. The stimulus sends a full reference and part of a noisy readout with different content, then restarts with a new seed, limit and count. The results must match the second run alone. The clamp and the padding bits are reached in the same way: the bench requests more readouts than the counters can hold, and it drives ones into the unused bits of the last word.

// File: rtl/puf_eval_pkg.sv
package puf_eval_pkg;
   localparam int PCT_FULL = 25600;
   localparam int PCT_HALF = 12800;
   localparam int PCT_W    = 15;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_REF,
      ST_NOISY,
      ST_DIV_UNREL,
      ST_DIV_HW
   } eval_state_e;
endpackage

// File: rtl/puf_eval_lane.sv
module puf_eval_lane #(
   parameter int WORD_W = 16,
   parameter int CNT_W  = 4,
   localparam int LCNT_W = $clog2(WORD_W + 1)
) (
   input  logic [WORD_W-1:0]       ref_w,
   input  logic [WORD_W-1:0]       data_w,
   input  logic [WORD_W-1:0]       cell_mask,
   input  logic [WORD_W*CNT_W-1:0] cnt_in,
   input  logic [CNT_W-1:0]        limit,
   output logic [WORD_W*CNT_W-1:0] cnt_out,
   output logic [LCNT_W-1:0]       unrel_n,
   output logic [LCNT_W-1:0]       ones_n
);
   logic [WORD_W-1:0] unrel_bits;
   logic [WORD_W-1:0] one_bits;

   for (genvar b = 0; b < WORD_W; b++) begin : g_cell
      logic [CNT_W-1:0] old_c;
      logic [CNT_W-1:0] new_c;
      logic             flip;
      assign old_c = cnt_in[b*CNT_W +: CNT_W];
      assign flip  = (ref_w[b] ^ data_w[b]) & cell_mask[b];
      assign new_c = (flip && (old_c != {CNT_W{1'b1}})) ? old_c + 1'b1 : old_c;
      assign cnt_out[b*CNT_W +: CNT_W] = new_c;
      assign unrel_bits[b] = cell_mask[b] & (new_c > limit);
      assign one_bits[b]   = cell_mask[b] & data_w[b];
   end

   always_comb begin
      unrel_n = '0;
      ones_n  = '0;
      for (int i = 0; i < WORD_W; i++) begin
         unrel_n = unrel_n + LCNT_W'(unrel_bits[i]);
         ones_n  = ones_n + LCNT_W'(one_bits[i]);
      end
   end
endmodule

// File: rtl/puf_eval_div.sv
module puf_eval_div #(
   parameter int N_W = 25,
   parameter int D_W = 10,
   localparam int STEP_W = $clog2(N_W + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           go,
   input  logic [N_W-1:0] dividend,
   input  logic [D_W-1:0] divisor,
   output logic           done,
   output logic [N_W-1:0] quotient
);
   logic [D_W-1:0]    rem;
   logic [N_W-1:0]    q;
   logic [STEP_W-1:0] step;
   logic              busy;
   logic [D_W:0]      sh;
   logic [D_W:0]      diff;
   logic              ge;

   always_comb begin
      sh   = {rem, q[N_W-1]};
      ge   = sh >= {1'b0, divisor};
      diff = sh - {1'b0, divisor};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem  <= '0;
         q    <= '0;
         step <= '0;
         busy <= 1'b0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (go) begin
            q    <= dividend;
            rem  <= '0;
            step <= STEP_W'(N_W);
            busy <= 1'b1;
         end else if (busy) begin
            rem  <= ge ? diff[D_W-1:0] : sh[D_W-1:0];
            q    <= {q[N_W-2:0], ge};
            step <= step - 1'b1;
            if (step == STEP_W'(1)) begin
               busy <= 1'b0;
               done <= 1'b1;
            end
         end
      end
   end

   assign quotient = q;

   assert_rem_below_R5: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (rem < divisor));
endmodule

// File: rtl/puf_quality_eval.sv
module puf_quality_eval #(
   parameter int CELLS     = 1000,
   parameter int WORD_W    = 16,
   parameter int MAX_NOISY = 15,
   parameter int CFG_W     = 8,
   localparam int WORDS   = (CELLS + WORD_W - 1) / WORD_W,
   localparam int WIDX_W  = $clog2(WORDS),
   localparam int CNT_W   = $clog2(MAX_NOISY + 1),
   localparam int CELL_W  = $clog2(CELLS + 1),
   localparam int LCNT_W  = $clog2(WORD_W + 1),
   localparam int DIVD_W  = $clog2(CELLS * puf_eval_pkg::PCT_FULL + 1),
   localparam int PCT_W   = puf_eval_pkg::PCT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_start,
   input  logic              in_sweep_new,
   input  logic [CFG_W-1:0]  cfg_noisy_runs,
   input  logic [CFG_W-1:0]  cfg_flip_limit,
   input  logic              in_valid,
   input  logic [WORD_W-1:0] in_word,
   output logic              in_ready,
   output logic              res_done,
   output logic [CELL_W-1:0] res_unrel_cnt,
   output logic [PCT_W-1:0]  res_unrel_pct,
   output logic [CELL_W-1:0] res_hw,
   output logic [PCT_W-1:0]  res_uni_dev,
   output logic [PCT_W-1:0]  res_max_unrel_pct,
   output logic [PCT_W-1:0]  res_max_uni_dev
);
   import puf_eval_pkg::*;

   if (WORDS < 2) begin : g_bad_words
      $error("puf_quality_eval: CELLS must span at least two words");
   end
   if (MAX_NOISY < 1 || MAX_NOISY >= (1 << CFG_W)) begin : g_bad_noisy
      $error("puf_quality_eval: MAX_NOISY out of range for CFG_W");
   end
   if (DIVD_W > 31) begin : g_bad_cells
      $error("puf_quality_eval: CELLS too large for the divider");
   end

   eval_state_e state;

   logic [WORD_W-1:0]       ref_mem [WORDS];
   logic [WORD_W*CNT_W-1:0] cnt_mem [WORDS];

   logic [WIDX_W-1:0] widx;
   logic [CNT_W-1:0]  run_idx;
   logic [CNT_W-1:0]  n_lat;
   logic [CNT_W-1:0]  t_lat;
   logic [CELL_W-1:0] hw_acc;
   logic [CELL_W-1:0] unrel_acc;
   logic [PCT_W-1:0]  pct_unrel_hold;

   logic [WORD_W-1:0]       cell_mask;
   logic [WORD_W*CNT_W-1:0] cnt_next;
   logic [LCNT_W-1:0]       unrel_n;
   logic [LCNT_W-1:0]       ones_n;

   logic              last_word;
   logic              last_run;
   logic              take_ref;
   logic              take_noisy;
   logic              div_go;
   logic              div_done;
   logic [DIVD_W-1:0] div_num;
   logic [DIVD_W-1:0] div_q;
   logic [PCT_W-1:0]  pct_hw;
   logic [PCT_W-1:0]  dev_now;
   logic [CNT_W-1:0]  n_clamped;
   logic [CNT_W-1:0]  t_clamped;

   // cells above CELLS-1 in the last word are padding
   for (genvar b = 0; b < WORD_W; b++) begin : g_mask
      assign cell_mask[b] = (int'(widx) * WORD_W + b) < CELLS;
   end

   puf_eval_lane #(
      .WORD_W(WORD_W),
      .CNT_W (CNT_W)
   ) u_lane (
      .ref_w    (ref_mem[widx]),
      .data_w   (in_word),
      .cell_mask(cell_mask),
      .cnt_in   (cnt_mem[widx]),
      .limit    (t_lat),
      .cnt_out  (cnt_next),
      .unrel_n  (unrel_n),
      .ones_n   (ones_n)
   );

   assign div_num = (state == ST_DIV_UNREL)
                  ? DIVD_W'(unrel_acc) * DIVD_W'(PCT_FULL)
                  : DIVD_W'(hw_acc) * DIVD_W'(PCT_FULL);

   puf_eval_div #(
      .N_W(DIVD_W),
      .D_W(CELL_W)
   ) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .go      (div_go),
      .dividend(div_num),
      .divisor (CELL_W'(CELLS)),
      .done    (div_done),
      .quotient(div_q)
   );

   always_comb begin
      in_ready   = (state == ST_REF) || (state == ST_NOISY);
      last_word  = (widx == WIDX_W'(WORDS - 1));
      last_run   = (run_idx == n_lat - 1'b1);
      take_ref   = !in_start && (state == ST_REF) && in_valid;
      take_noisy = !in_start && (state == ST_NOISY) && in_valid;
      pct_hw     = PCT_W'(div_q);
      dev_now    = (pct_hw >= PCT_W'(PCT_HALF)) ? pct_hw - PCT_W'(PCT_HALF)
                                                 : PCT_W'(PCT_HALF) - pct_hw;
      n_clamped  = (cfg_noisy_runs > CFG_W'(MAX_NOISY)) ? CNT_W'(MAX_NOISY)
                                                         : CNT_W'(cfg_noisy_runs);
      t_clamped  = (cfg_flip_limit > CFG_W'(MAX_NOISY)) ? CNT_W'(MAX_NOISY)
                                                         : CNT_W'(cfg_flip_limit);
   end

   // signature and counter storage, no reset needed: written before use
   always_ff @(posedge clk) begin
      if (take_ref) begin
         ref_mem[widx] <= in_word;
         cnt_mem[widx] <= '0;
      end else if (take_noisy) begin
         cnt_mem[widx] <= cnt_next;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state             <= ST_IDLE;
         widx              <= '0;
         run_idx           <= '0;
         n_lat             <= '0;
         t_lat             <= '0;
         hw_acc            <= '0;
         unrel_acc         <= '0;
         pct_unrel_hold    <= '0;
         div_go            <= 1'b0;
         res_done          <= 1'b0;
         res_unrel_cnt     <= '0;
         res_unrel_pct     <= '0;
         res_hw            <= '0;
         res_uni_dev       <= '0;
         res_max_unrel_pct <= '0;
         res_max_uni_dev   <= '0;
      end else begin
         div_go   <= 1'b0;
         res_done <= 1'b0;
         if (in_start) begin
            state     <= ST_REF;
            widx      <= '0;
            run_idx   <= '0;
            hw_acc    <= '0;
            unrel_acc <= '0;
            n_lat     <= n_clamped;
            t_lat     <= t_clamped;
            if (in_sweep_new) begin
               res_max_unrel_pct <= '0;
               res_max_uni_dev   <= '0;
            end
         end else begin
            unique case (state)
               ST_REF: begin
                  if (in_valid) begin
                     hw_acc <= hw_acc + CELL_W'(ones_n);
                     if (last_word) begin
                        widx <= '0;
                        if (n_lat == '0) begin
                           state  <= ST_DIV_UNREL;
                           div_go <= 1'b1;
                        end else begin
                           state <= ST_NOISY;
                        end
                     end else begin
                        widx <= widx + 1'b1;
                     end
                  end
               end
               ST_NOISY: begin
                  if (in_valid) begin
                     if (last_run) unrel_acc <= unrel_acc + CELL_W'(unrel_n);
                     if (last_word) begin
                        widx <= '0;
                        if (last_run) begin
                           state  <= ST_DIV_UNREL;
                           div_go <= 1'b1;
                        end else begin
                           run_idx <= run_idx + 1'b1;
                        end
                     end else begin
                        widx <= widx + 1'b1;
                     end
                  end
               end
               ST_DIV_UNREL: begin
                  if (div_done && !div_go) begin
                     pct_unrel_hold <= PCT_W'(div_q);
                     state          <= ST_DIV_HW;
                     div_go         <= 1'b1;
                  end
               end
               ST_DIV_HW: begin
                  if (div_done && !div_go) begin
                     res_unrel_cnt <= unrel_acc;
                     res_unrel_pct <= pct_unrel_hold;
                     res_hw        <= hw_acc;
                     res_uni_dev   <= dev_now;
                     if (pct_unrel_hold > res_max_unrel_pct) res_max_unrel_pct <= pct_unrel_hold;
                     if (dev_now > res_max_uni_dev) res_max_uni_dev <= dev_now;
                     res_done <= 1'b1;
                     state    <= ST_IDLE;
                  end
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      res_done |=> !res_done);
   assert_no_ready_at_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      res_done |-> !in_ready);
   assert_max_covers_R8: assert property (@(posedge clk) disable iff (!rst_n)
      res_done |-> (res_max_unrel_pct >= res_unrel_pct) && (res_max_uni_dev >= res_uni_dev));
   assert_pct_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      res_done |-> (res_unrel_pct <= PCT_W'(PCT_FULL)));
   assert_unrel_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      res_unrel_cnt <= CELL_W'(CELLS));
   assert_hw_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      res_hw <= CELL_W'(CELLS));
   assert_dev_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      res_uni_dev <= PCT_W'(PCT_HALF));
   assert_run_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_NOISY) |-> (run_idx < n_lat));
endmodule

// File: tb/puf_quality_eval_bench.sv
module puf_quality_eval_bench;
   localparam int CELLS = 1000;
   localparam int WW    = 16;
   localparam int MAXN  = 15;
   localparam int WORDS = (CELLS + WW - 1) / WW;

   typedef struct {
      int unrel;
      int pct;
      int hw;
      int dev;
      int maxp;
      int maxd;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_start = 1'b0;
   logic          in_sweep_new = 1'b0;
   logic [7:0]    cfg_noisy_runs = '0;
   logic [7:0]    cfg_flip_limit = '0;
   logic          in_valid = 1'b0;
   logic [WW-1:0] in_word = '0;
   logic          in_ready;
   logic          res_done;
   logic [9:0]    res_unrel_cnt;
   logic [14:0]   res_unrel_pct;
   logic [9:0]    res_hw;
   logic [14:0]   res_uni_dev;
   logic [14:0]   res_max_unrel_pct;
   logic [14:0]   res_max_uni_dev;

   int checks = 0;
   int failures = 0;
   int cycles = 0;
   int model_maxp = 0;
   int model_maxd = 0;
   exp_t q[$];

   always #10 clk = ~clk;

   puf_quality_eval u_puf_quality_eval (
      .clk(clk), .rst_n(rst_n), .in_start(in_start), .in_sweep_new(in_sweep_new),
      .cfg_noisy_runs(cfg_noisy_runs), .cfg_flip_limit(cfg_flip_limit),
      .in_valid(in_valid), .in_word(in_word), .in_ready(in_ready),
      .res_done(res_done), .res_unrel_cnt(res_unrel_cnt), .res_unrel_pct(res_unrel_pct),
      .res_hw(res_hw), .res_uni_dev(res_uni_dev),
      .res_max_unrel_pct(res_max_unrel_pct), .res_max_uni_dev(res_max_uni_dev));

   task automatic chk(input string tag, input int got, input int exp);
      checks++;
      if (got != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
      end
   endtask

   function automatic bit ref_bit(input int c, input int seed, input bit ones);
      return ones ? 1'b1 : (((c * 7 + seed * 13) % 5) < 2);
   endfunction

   function automatic bit flip_bit(input int c, input int r, input int seed);
      return ((c * 3 + r * 5 + seed * 11) % (7 + seed)) == 0;
   endfunction

   // r < 0 sends the reference; padding cells are driven to one
   task automatic send_readout(input int r, input int seed, input bit ones, input int nwords);
      for (int w = 0; w < nwords; w++) begin
         logic [WW-1:0] v;
         for (int b = 0; b < WW; b++) begin
            int c = w * WW + b;
            if (c >= CELLS) v[b] = 1'b1;
            else v[b] = ref_bit(c, seed, ones) ^ ((r >= 0) ? flip_bit(c, r, seed) : 1'b0);
         end
         @(negedge clk);
         while (!in_ready) @(negedge clk);
         in_valid = 1'b1;
         in_word  = v;
      end
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic pulse_start(input int n, input int t, input bit sweep);
      @(negedge clk);
      in_start = 1'b1;
      in_sweep_new = sweep;
      cfg_noisy_runs = 8'(n);
      cfg_flip_limit = 8'(t);
      @(negedge clk);
      in_start = 1'b0;
      in_sweep_new = 1'b0;
   endtask

   // full run: expected results computed from the requirements and queued
   task automatic run_eval(input int n, input int t, input bit sweep, input int seed, input bit ones);
      int ne;
      int hw;
      int unrel;
      int hp;
      exp_t e;
      ne = (n > MAXN) ? MAXN : n;                       // R11 clamp
      hw = 0;
      unrel = 0;
      for (int c = 0; c < CELLS; c++) begin
         int fc = 0;
         hw += ref_bit(c, seed, ones);                  // R6
         for (int r = 0; r < ne; r++) fc += flip_bit(c, r, seed);
         if (fc > ((t > MAXN) ? MAXN : t)) unrel++;     // R3 R4
      end
      if (sweep) begin
         model_maxp = 0;
         model_maxd = 0;
      end
      e.unrel = unrel;
      e.pct   = (unrel * 25600) / CELLS;                // R5
      e.hw    = hw;
      hp      = (hw * 25600) / CELLS;
      e.dev   = (hp >= 12800) ? hp - 12800 : 12800 - hp; // R7
      if (e.pct > model_maxp) model_maxp = e.pct;       // R8
      if (e.dev > model_maxd) model_maxd = e.dev;
      e.maxp = model_maxp;
      e.maxd = model_maxd;
      pulse_start(n, t, sweep);
      chk("R2 ready after start", int'(in_ready), 1);
      q.push_back(e);
      send_readout(-1, seed, ones, WORDS);
      for (int r = 0; r < ne; r++) send_readout(r, seed, ones, WORDS);
      for (int k = 0; k < 200 && q.size() != 0; k++) @(negedge clk);
      chk("R9 run completed", q.size(), 0);
      chk("R9 ready low after done", int'(in_ready), 0);
   endtask

   // monitor: pops expectations on each completion pulse
   always @(negedge clk) begin
      if (rst_n && res_done) begin
         if (q.size() == 0) begin
            chk("R9 unexpected done", 1, 0);
         end else begin
            exp_t e;
            e = q.pop_front();
            chk("R3 unstable count", int'(res_unrel_cnt), e.unrel);
            chk("R5 unstable pct", int'(res_unrel_pct), e.pct);
            chk("R6 weight", int'(res_hw), e.hw);
            chk("R7 balance dev", int'(res_uni_dev), e.dev);
            chk("R8 max pct", int'(res_max_unrel_pct), e.maxp);
            chk("R8 max dev", int'(res_max_uni_dev), e.maxd);
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 200000) begin
         failures++;
         checks++;
         $display("FAIL watchdog actual=%0d expected<=200000", cycles);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 ready", int'(in_ready), 0);
      chk("R1 done", int'(res_done), 0);
      chk("R1 count", int'(res_unrel_cnt), 0);
      chk("R1 max pct", int'(res_max_unrel_pct), 0);
      // R3 R4: limit 0, ten readouts
      run_eval(10, 0, 1'b1, 1, 1'b0);
      // R3 R8: looser limit, max kept from the first run
      run_eval(10, 2, 1'b0, 2, 1'b0);
      // R9 R6 R7: no noisy readouts, all-ones signature
      run_eval(0, 0, 1'b0, 3, 1'b1);
      // R11 R4: count clamped to 15, limit at count gives none unstable
      run_eval(20, 15, 1'b0, 4, 1'b0);
      // R10: abandon a run part way through a noisy readout
      pulse_start(10, 0, 1'b0);
      send_readout(-1, 6, 1'b1, WORDS);
      send_readout(0, 6, 1'b1, 20);
      run_eval(5, 1, 1'b0, 5, 1'b0);
      // R8: sweep restart clears the maxima
      run_eval(3, 0, 1'b1, 2, 1'b0);
      repeat (5) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule